// File: doc/BRIEF.md
# Incremental nybble DMA address loader

This block assembles a 24-bit DMA start address and a transfer direction from a stream of byte writes that land in one control window of a 16-bit local bus. The address is never loaded in parallel. A preset write first fills every nybble with 7 and arms the transfer. Later writes shape the nybbles one mask at a time. Each low data bit selects one nybble. Early in the sequence, a cleared bit clamps its nybble down to a ceiling that grows with each write. Late in the sequence, a set bit adds one to its nybble.

Software reaches any nybble value from 0 to 15 by choosing which bits to clear in each of the first eight writes, then which bits to set in the later writes. The direction flag follows bit 7 of every write that hits the window. The address, direction and armed flag drive the byte mover outside this block.

Top module: `nyb_dma_loader`

## Requirements
- R1: Only writes with address bits 15:14 equal to 2'b10 have any effect. Any other write leaves the address, the direction and the armed flag unchanged.
- R2: A window write with data bit 6 set loads 0x777777 into the address, sets the internal sequence count to 1 and raises the armed flag. This holds whatever the other data bits are.
- R3: A shaping write is a window write with data bits 7:6 clear and nonzero data. When the count is 1 to 8 before such a write, every nybble i (i = 0..5, with nybble 0 at address bits 3:0) whose data bit i is clear becomes min(nybble, count-1). The count then rises by one. While the count is 0 (after reset), a shaping write changes nothing.
- R4: When the count is above 8, a shaping write adds one, modulo 16, to every nybble i whose data bit i is set. Nybbles with a clear bit stay as they are, and the count does not change.
- R5: A shaping write made while the count is exactly 8 does both things in the same write. It clamps the nybbles with clear bits to at most 7. It then increments the nybbles with set bits, and the count becomes 9.
- R6: Every window write, presets included, copies data bit 7 into the direction output.
- R7: A window write of 0x00 leaves the address and the count unchanged.
- R8: The active-low asynchronous reset clears the address, the count, the direction and the armed flag. Once set, the armed flag stays high until reset.
- R9: The result of a write shows on the outputs after the clock edge that samples the write. The count never exceeds 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Bus write strobe, one cycle per write |
| wr_addr_i | input | 16 | Bus write address |
| wr_data_i | input | 8 | Bus write data byte |
| dma_addr_o | output | 24 | Assembled DMA start address |
| dma_dir_o | output | 1 | Transfer direction, last bit 7 written |
| dma_armed_o | output | 1 | High from the first preset until reset |

## Verification
Clamping and incrementing both act in one write when the count stands at 8. The clamp touches the nybbles whose bits are clear, and the increment touches the nybbles whose bits are set. The bench reaches this case by following a preset with seven shaping writes and then sending a mixed mask such as 0x2A. A reference model applies the clamp first and the increment second, and the bench compares all six nybbles on the next cycle. Further single-bit writes then drive one nybble through its wrap from 15 to 0. Each preset also changes the direction in the same cycle, and the bench checks the direction against the preset data as well.

// File: rtl/nyb_dma_pkg.sv
package nyb_dma_pkg;
  localparam int unsigned NYB_W      = 4;
  localparam int unsigned PRESET_BIT = 6;
  localparam int unsigned DIR_BIT    = 7;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_CLAMP = 2'd1,
    PH_BOTH  = 2'd2,
    PH_INC   = 2'd3
  } seq_phase_e;
endpackage

// File: rtl/nyb_dma_win_dec.sv
module nyb_dma_win_dec #(
  parameter int unsigned SEL_W  = 2,
  parameter logic [SEL_W-1:0] WIN_SEL = 2'b10,
  parameter int unsigned DATA_W = 8
) (
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  addr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              hit_o,
  output logic              preset_o,
  output logic              shape_o
);
  import nyb_dma_pkg::*;

  logic ctl_clear;

  assign hit_o     = wr_en_i && (addr_sel_i == WIN_SEL);
  assign ctl_clear = !wr_data_i[DIR_BIT] && !wr_data_i[PRESET_BIT];
  assign preset_o  = hit_o && wr_data_i[PRESET_BIT];
  // zero data is a no-op write
  assign shape_o   = hit_o && ctl_clear && (wr_data_i != '0);
endmodule

// File: rtl/nyb_dma_seq_cnt.sv
module nyb_dma_seq_cnt #(
  parameter int unsigned CNT_W      = 4,
  parameter int unsigned CLAMP_LAST = 8,
  parameter int unsigned NYB_W      = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   preset_i,
  input  logic                   shape_i,
  output logic                   clamp_en_o,
  output logic                   inc_en_o,
  output logic [NYB_W-1:0]       limit_o,
  output logic [CNT_W-1:0]       cnt_o
);
  import nyb_dma_pkg::*;

  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CLAMP_LAST);
  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_m1;
  seq_phase_e       phase;

  always_comb begin
    if (cnt_q == '0)           phase = PH_IDLE;
    else if (cnt_q < CNT_LAST) phase = PH_CLAMP;
    else if (cnt_q == CNT_LAST) phase = PH_BOTH;
    else                       phase = PH_INC;
  end

  assign clamp_en_o = shape_i && ((phase == PH_CLAMP) || (phase == PH_BOTH));
  assign inc_en_o   = shape_i && ((phase == PH_BOTH) || (phase == PH_INC));
  assign cnt_m1     = cnt_q - CNT_W'(1);
  assign limit_o    = cnt_m1[NYB_W-1:0];
  assign cnt_o      = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (preset_i)
      cnt_d = CNT_W'(1);
    else if (clamp_en_o && (cnt_q != CNT_MAX))
      cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end
endmodule

// File: rtl/nyb_dma_lane.sv
module nyb_dma_lane #(
  parameter int unsigned NYB_W = 4,
  parameter logic [NYB_W-1:0] PRESET_VAL = 4'h7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             preset_i,
  input  logic             clamp_en_i,
  input  logic             inc_en_i,
  input  logic             sel_i,
  input  logic [NYB_W-1:0] limit_i,
  output logic [NYB_W-1:0] nyb_o
);
  logic [NYB_W-1:0] nyb_q, clamped, nyb_d;

  // clamp applies to clear-bit lanes, increment to set-bit lanes
  assign clamped = (clamp_en_i && !sel_i && (nyb_q > limit_i)) ? limit_i : nyb_q;

  always_comb begin
    if (preset_i)              nyb_d = PRESET_VAL;
    else if (inc_en_i && sel_i) nyb_d = clamped + NYB_W'(1);
    else                       nyb_d = clamped;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) nyb_q <= '0;
    else         nyb_q <= nyb_d;
  end

  assign nyb_o = nyb_q;
endmodule

// File: rtl/nyb_dma_loader.sv
module nyb_dma_loader #(
  parameter int unsigned BUS_AW     = 16,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned ADDR_W     = 24,
  parameter int unsigned CLAMP_LAST = 8,
  parameter logic [3:0]  PRESET_NYB = 4'h7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [BUS_AW-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [ADDR_W-1:0] dma_addr_o,
  output logic              dma_dir_o,
  output logic              dma_armed_o
);
  import nyb_dma_pkg::*;

  localparam int unsigned NYB_N = ADDR_W / NYB_W;
  localparam int unsigned CNT_W = $clog2(CLAMP_LAST + 2);
  localparam int unsigned SEL_W = 2;

  logic             hit_w, preset_w, shape_w;
  logic             clamp_en_w, inc_en_w;
  logic [NYB_W-1:0] limit_w;
  logic [CNT_W-1:0] cnt_w;
  logic             dir_q, armed_q;
  logic             unused_addr_lo;

  assign unused_addr_lo = ^wr_addr_i[BUS_AW-SEL_W-1:0];

  nyb_dma_win_dec #(
    .SEL_W  (SEL_W),
    .WIN_SEL(2'b10),
    .DATA_W (DATA_W)
  ) u_dec (
    .wr_en_i   (wr_en_i),
    .addr_sel_i(wr_addr_i[BUS_AW-1 -: SEL_W]),
    .wr_data_i (wr_data_i),
    .hit_o     (hit_w),
    .preset_o  (preset_w),
    .shape_o   (shape_w)
  );

  nyb_dma_seq_cnt #(
    .CNT_W     (CNT_W),
    .CLAMP_LAST(CLAMP_LAST),
    .NYB_W     (NYB_W)
  ) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .preset_i  (preset_w),
    .shape_i   (shape_w),
    .clamp_en_o(clamp_en_w),
    .inc_en_o  (inc_en_w),
    .limit_o   (limit_w),
    .cnt_o     (cnt_w)
  );

  for (genvar g = 0; g < NYB_N; g++) begin : g_lane
    nyb_dma_lane #(
      .NYB_W     (NYB_W),
      .PRESET_VAL(PRESET_NYB)
    ) u_lane (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .preset_i  (preset_w),
      .clamp_en_i(clamp_en_w),
      .inc_en_i  (inc_en_w),
      .sel_i     (wr_data_i[g]),
      .limit_i   (limit_w),
      .nyb_o     (dma_addr_o[g*NYB_W +: NYB_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (hit_w)    dir_q   <= wr_data_i[DIR_BIT];
      if (preset_w) armed_q <= 1'b1;
    end
  end

  assign dma_dir_o   = dir_q;
  assign dma_armed_o = armed_q;
endmodule

// File: rtl/nyb_dma_chk.sv
module nyb_dma_chk #(
  parameter int unsigned BUS_AW     = 16,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned ADDR_W     = 24,
  parameter int unsigned CNT_W      = 4,
  parameter int unsigned CLAMP_LAST = 8,
  parameter logic [3:0]  PRESET_NYB = 4'h7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [BUS_AW-1:0] wr_addr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [ADDR_W-1:0] dma_addr_o,
  input logic              dma_dir_o,
  input logic              dma_armed_o,
  input logic [CNT_W-1:0]  cnt_i
);
  localparam int unsigned NYB_N = ADDR_W / 4;
  logic in_win;
  assign in_win = wr_en_i && (wr_addr_i[BUS_AW-1 -: 2] == 2'b10);

  a_r1_outside_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_win |=> $stable(dma_addr_o) && $stable(dma_dir_o) && $stable(dma_armed_o));

  a_r2_preset_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_win && wr_data_i[6] |=> (dma_addr_o == {NYB_N{PRESET_NYB}}) && dma_armed_o
                               && (cnt_i == CNT_W'(1)));

  a_r6_dir_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_win |=> dma_dir_o == $past(wr_data_i[7]));

  a_r7_zero_no_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_win && (wr_data_i == '0) |=> $stable(dma_addr_o) && $stable(cnt_i));

  a_r8_armed_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_armed_o |=> dma_armed_o);

  a_r9_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= CNT_W'(CLAMP_LAST + 1));
endmodule

bind nyb_dma_loader nyb_dma_chk #(
  .BUS_AW    (BUS_AW),
  .DATA_W    (DATA_W),
  .ADDR_W    (ADDR_W),
  .CNT_W     (CNT_W),
  .CLAMP_LAST(CLAMP_LAST),
  .PRESET_NYB(PRESET_NYB)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .wr_addr_i  (wr_addr_i),
  .wr_data_i  (wr_data_i),
  .dma_addr_o (dma_addr_o),
  .dma_dir_o  (dma_dir_o),
  .dma_armed_o(dma_armed_o),
  .cnt_i      (cnt_w)
);

// File: tb/nyb_dma_loader_tb_top.sv
`timescale 1ns/1ps
module nyb_dma_loader_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [23:0] dma_addr;
  logic        dma_dir, dma_armed;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  nyb_dma_loader dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .wr_en_i    (wr_en),
    .wr_addr_i  (wr_addr),
    .wr_data_i  (wr_data),
    .dma_addr_o (dma_addr),
    .dma_dir_o  (dma_dir),
    .dma_armed_o(dma_armed)
  );

  typedef struct {
    logic [23:0] a;
    logic        dir;
    logic        armed;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  logic [23:0] m_addr = '0;
  int          m_cnt = 0;
  logic        m_dir = 1'b0;
  logic        m_armed = 1'b0;

  task automatic model_reset();
    m_addr = '0; m_cnt = 0; m_dir = 1'b0; m_armed = 1'b0;
  endtask

  task automatic model_write(input logic [15:0] a, input logic [7:0] d);
    logic [3:0] n;
    if (a[15:14] != 2'b10) return;
    m_dir = d[7];
    if (d[6]) begin
      m_addr = 24'h777777; m_cnt = 1; m_armed = 1'b1;
    end else if (d[7:6] == 2'b00 && d != 8'h00) begin
      if (m_cnt >= 1 && m_cnt <= 8) begin
        for (int i = 0; i < 6; i++) begin
          n = m_addr[i*4 +: 4];
          if (!d[i] && n > 4'(m_cnt - 1)) m_addr[i*4 +: 4] = 4'(m_cnt - 1);
        end
        m_cnt = m_cnt + 1;
      end
      if (m_cnt > 8) begin
        for (int i = 0; i < 6; i++)
          if (d[i]) m_addr[i*4 +: 4] = m_addr[i*4 +: 4] + 4'd1;
      end
    end
  endtask

  task automatic check(input string tag, input string what, input logic [23:0] act,
                       input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %06h expected %06h", tag, what, act, exp);
    end
  endtask

  // driver: push the expected state for each write
  task automatic wr(input logic [15:0] a, input logic [7:0] d, input string tag);
    exp_t e;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    model_write(a, d);
    e.a = m_addr; e.dir = m_dir; e.armed = m_armed; e.tag = tag;
    sb_q.push_back(e);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // monitor: compare after the edge that samples the write
  initial begin
    forever begin
      @(posedge clk);
      #2;
      while (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        check(e.tag, "addr", dma_addr, e.a);
        check(e.tag, "dir", {23'd0, dma_dir}, {23'd0, e.dir});
        check(e.tag, "armed", {23'd0, dma_armed}, {23'd0, e.armed});
      end
    end
  end

  task automatic check_idle(input string tag);
    @(negedge clk);
    check(tag, "addr", dma_addr, m_addr);
    check(tag, "dir", {23'd0, dma_dir}, {23'd0, m_dir});
    check(tag, "armed", {23'd0, dma_armed}, {23'd0, m_armed});
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    check_idle("R8 reset state");
    rst_n = 1'b1;
    check_idle("R8 after release");

    wr(16'h8000, 8'h01, "R3 shape with count 0");
    wr(16'h4000, 8'h40, "R1 outside window 01");
    wr(16'hC000, 8'hC0, "R1 outside window 11");
    wr(16'h0002, 8'h80, "R1 outside window 00");

    wr(16'h8000, 8'hC0, "R2 preset dir 1");
    wr(16'hBFFE, 8'h40, "R2 preset dir 0");
    wr(16'h8000, 8'h00, "R7 zero write");

    wr(16'h8000, 8'h3E, "R3 clamp limit 0");
    wr(16'h8002, 8'h3D, "R3 clamp limit 1");
    wr(16'h8000, 8'h00, "R7 zero keeps count");
    wr(16'h8000, 8'h3B, "R3 clamp limit 2");
    wr(16'h8000, 8'h80, "R6 dir only write");
    wr(16'h8000, 8'h37, "R3 clamp limit 3");
    wr(16'h4000, 8'h01, "R1 outside during sequence");
    wr(16'h8000, 8'h2F, "R3 clamp limit 4");
    wr(16'h8000, 8'h1F, "R3 clamp limit 5");
    wr(16'h8000, 8'h3F, "R3 clamp none limit 6");
    wr(16'h8000, 8'h2A, "R5 clamp and inc at count 8");
    for (int k = 0; k < 17; k++) wr(16'h8000, 8'h01, "R4 increment wrap");
    wr(16'h8000, 8'h30, "R4 increment upper");
    wr(16'h8000, 8'h00, "R7 zero after inc");
    wr(16'h8000, 8'h80, "R6 dir set late");

    // second sequence: direct jump to count 8 mask after preset
    wr(16'h8000, 8'h40, "R2 re-preset");
    for (int k = 0; k < 7; k++) wr(16'h8000, 8'h3F, "R3 no-op clamps");
    wr(16'h8000, 8'h15, "R5 mixed mask at count 8");
    wr(16'h8000, 8'h15, "R4 after R5");

    @(negedge clk);
    rst_n = 1'b0;
    model_reset();
    check_idle("R8 async reset mid run");
    @(negedge clk);
    rst_n = 1'b1;
    wr(16'h8000, 8'h3F, "R3 shape ignored after reset");
    check_idle("R9 hold without write");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule